// File: doc/BRIEF.md
# Multi-Cycle Operand Address Generator

This block produces the 16-bit operand address for a small processor whose only arithmetic unit is a byte-wide adder. A request carries a mode, a 16-bit operand taken from the instruction and an 8-bit index value. The block then reports the final address with a one-cycle completion pulse. The 16-bit operand is either a full address or, for the pointer mode, a byte in its lower half that points into page zero.

Three modes are supported:

- **Direct mode** passes the instruction address through unchanged.
- **Offset mode** adds the index to a 16-bit base.
- **Pointer mode** reads a two-byte pointer from page zero, then adds the index to it.

Every 16-bit sum is formed one byte at a time. The low byte is added first. The high byte is only incremented, in one extra cycle, when the low addition carries out. A flag reports whether that extra cycle was spent.

The pointer bytes are fetched through a simple read port. The read data is expected one cycle after the read strobe. The block does not decode instructions, perform the data operation or keep flags. A new request is taken only while the block is idle.

Top module: `operand_addr_unit`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `memRdEn` are all 0.
- R2: A request accepted with `reqMode` = 2'b00 (direct) raises `done` in the first cycle after the accepting edge. `finalAddr` then equals `reqOperand` and `pageCrossed` is 0.
- R3: A request with `reqMode` = 2'b01 (offset) whose low-byte sum `reqOperand[7:0] + reqIndex` stays below 256 raises `done` in the second cycle after acceptance. `finalAddr` is `reqOperand + reqIndex` and `pageCrossed` is 0.
- R4: An offset request whose low-byte sum carries raises `done` in the third cycle after acceptance. `finalAddr` is `(reqOperand + reqIndex) mod 65536` and `pageCrossed` is 1.
- R5: A request with `reqMode` = 2'b10 (pointer) drives `memRdEn` in exactly two consecutive cycles, the first and second after acceptance. The read addresses are `{8'h00, n}` and then `{8'h00, (n+1) mod 256}`, where n = `reqOperand[7:0]`. No other mode reads memory.
- R6: A pointer request forms the pointer little-endian: the byte read at n is the low byte, and the byte read at n+1 is the high byte. `done` rises in the fourth cycle after acceptance, or in the fifth when the low-byte sum `ptr[7:0] + reqIndex` carries. `finalAddr` is `(ptr + reqIndex) mod 65536` and `pageCrossed` shows whether the carry cycle was taken.
- R7: `done` is a single-cycle pulse. `busy` is 1 from the first cycle after acceptance through the `done` cycle, and 0 in the cycle after `done`.
- R8: `reqValid` and the request fields are ignored while `busy` is 1; they change neither the result nor the timing of the request in flight.
- R9: `reqMode` = 2'b11 behaves exactly like direct mode.
- R10: `finalAddr` and `pageCrossed` keep their values after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqMode | input | 2 | 00 direct, 01 offset, 10 pointer, 11 as direct |
| reqOperand | input | 16 | Instruction address, base, or page-zero pointer location in bits 7:0 |
| reqIndex | input | 8 | Index value added in offset and pointer modes |
| memRdEn | output | 1 | Read strobe for a pointer byte |
| memRdAddr | output | 16 | Address of the pointer byte being read |
| memRdData | input | 8 | Read data, valid one cycle after `memRdEn` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: final address valid |
| finalAddr | output | 16 | Computed operand address |
| pageCrossed | output | 1 | The high-byte carry cycle was taken |

## Verification
The hardest case to reach from the ports is a pointer whose high-byte location wraps from 0xFF to 0x00 and whose low byte then also carries when the index is added. That case exercises both the page-zero wrap and the extra cycle in one request, so it needs a chosen pointer location and chosen memory contents. Directed requests set the page-zero model so that location 0xFF holds a large low byte and location 0x00 a known high byte. The random stream draws full-range bases, indexes and memory contents, so carry and no-carry cases both occur often in every mode. Random requests also keep `reqValid` asserted with unrelated fields while the block is busy, to show that nothing in flight is disturbed.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam logic [1:0] MODE_DIRECT  = 2'b00;
  localparam logic [1:0] MODE_OFFSET  = 2'b01;
  localparam logic [1:0] MODE_POINTER = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADD_LO,
    ST_INC_HI,
    ST_RD_LO,
    ST_RD_HI,
    ST_GET_HI,
    ST_FIN
  } stateT;

  typedef struct packed {
    logic loadReq;   // capture operand, index and clear the carry flag
    logic addLo;     // low byte <= low byte + index
    logic incHi;     // high byte <= high byte + 1
    logic capLo;     // low byte <= read data
    logic capHi;     // high byte <= read data
    logic rdSecond;  // read address selects pointer location + 1
  } ctrlT;

endpackage

// File: rtl/opaddr_byte_adder.sv
module opaddr_byte_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  output logic [W-1:0] sumOut,
  output logic         cOut
);

  logic [W:0] carryChain;

  assign carryChain[0] = cIn;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sumOut[i]        = aIn[i] ^ bIn[i] ^ carryChain[i];
    assign carryChain[i+1]  = (aIn[i] & bIn[i]) | (aIn[i] & carryChain[i]) |
                              (bIn[i] & carryChain[i]);
  end

  assign cOut = carryChain[W];

endmodule

// File: rtl/opaddr_ctrl.sv
module opaddr_ctrl
  import opaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqMode,
  input  logic       carryOut,
  output ctrlT       ctrl,
  output logic       busy,
  output logic       done,
  output logic       memRdEn
);

  stateT state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    memRdEn   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.loadReq = 1'b1;
          if (reqMode == MODE_OFFSET)       stateNext = ST_ADD_LO;
          else if (reqMode == MODE_POINTER) stateNext = ST_RD_LO;
          else                              stateNext = ST_FIN;
        end
      end
      ST_ADD_LO: begin
        ctrl.addLo = 1'b1;
        stateNext  = carryOut ? ST_INC_HI : ST_FIN;
      end
      ST_INC_HI: begin
        ctrl.incHi = 1'b1;
        stateNext  = ST_FIN;
      end
      ST_RD_LO: begin
        memRdEn   = 1'b1;
        stateNext = ST_RD_HI;
      end
      ST_RD_HI: begin
        memRdEn       = 1'b1;
        ctrl.rdSecond = 1'b1;
        ctrl.capLo    = 1'b1;
        stateNext     = ST_GET_HI;
      end
      ST_GET_HI: begin
        ctrl.capHi = 1'b1;
        ctrl.addLo = 1'b1;
        stateNext  = carryOut ? ST_INC_HI : ST_FIN;
      end
      ST_FIN: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/opaddr_datapath.sv
module opaddr_datapath
  import opaddr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [ADDR_W-1:0] reqOperand,
  input  logic [BYTE_W-1:0] reqIndex,
  input  logic [BYTE_W-1:0] memRdData,
  output logic              carryOut,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] finalAddr,
  output logic              pageCrossed
);

  logic [BYTE_W-1:0] oarLo, oarHi, idxReg, zpReg;
  logic              crossReg;
  logic [BYTE_W-1:0] addA, addB, addSum, zpNext;
  logic              addCin;

  // one shared byte adder: low-byte add or high-byte increment
  always_comb begin
    if (ctrl.incHi) begin
      addA   = oarHi;
      addB   = '0;
      addCin = 1'b1;
    end else begin
      addA   = oarLo;
      addB   = idxReg;
      addCin = 1'b0;
    end
  end

  opaddr_byte_adder #(.W(BYTE_W)) adder_i (
    .aIn   (addA),
    .bIn   (addB),
    .cIn   (addCin),
    .sumOut(addSum),
    .cOut  (carryOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oarLo    <= '0;
      oarHi    <= '0;
      idxReg   <= '0;
      zpReg    <= '0;
      crossReg <= 1'b0;
    end else begin
      if (ctrl.loadReq) begin
        oarLo    <= reqOperand[BYTE_W-1:0];
        oarHi    <= reqOperand[ADDR_W-1:BYTE_W];
        idxReg   <= reqIndex;
        zpReg    <= reqOperand[BYTE_W-1:0];
        crossReg <= 1'b0;
      end
      if (ctrl.capLo) oarLo <= memRdData;
      if (ctrl.capHi) oarHi <= memRdData;
      if (ctrl.addLo) oarLo <= addSum;
      if (ctrl.incHi) begin
        oarHi    <= addSum;
        crossReg <= 1'b1;
      end
    end
  end

  // second pointer byte stays inside page zero
  assign zpNext      = zpReg + BYTE_W'(1);
  assign memRdAddr   = {{BYTE_W{1'b0}}, (ctrl.rdSecond ? zpNext : zpReg)};
  assign finalAddr   = {oarHi, oarLo};
  assign pageCrossed = crossReg;

endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import opaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqMode,
  input  logic [15:0] reqOperand,
  input  logic [7:0]  reqIndex,
  output logic        memRdEn,
  output logic [15:0] memRdAddr,
  input  logic [7:0]  memRdData,
  output logic        busy,
  output logic        done,
  output logic [15:0] finalAddr,
  output logic        pageCrossed
);

  ctrlT ctrl;
  logic carryOut;

  opaddr_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqMode (reqMode),
    .carryOut(carryOut),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done),
    .memRdEn (memRdEn)
  );

  opaddr_datapath #(.BYTE_W(8)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqOperand (reqOperand),
    .reqIndex   (reqIndex),
    .memRdData  (memRdData),
    .carryOut   (carryOut),
    .memRdAddr  (memRdAddr),
    .finalAddr  (finalAddr),
    .pageCrossed(pageCrossed)
  );

endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  reqMode,
  input logic [15:0] reqOperand,
  input logic        memRdEn,
  input logic [15:0] memRdAddr,
  input logic        busy,
  input logic        done,
  input logic [15:0] finalAddr,
  input logic        pageCrossed
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!done && !memRdEn));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  // R5
  rd_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memRdAddr[15:8] == 8'h00));

  // R5
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdEn) |=> (memRdEn && memRdAddr[7:0] == 8'($past(memRdAddr[7:0]) + 8'd1)));

  // R2
  direct_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqMode == 2'b00) |=>
      (done && finalAddr == $past(reqOperand) && !pageCrossed));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(reqValid)) |=> ($stable(finalAddr) && $stable(pageCrossed)));

endmodule

bind operand_addr_unit opaddr_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqMode    (reqMode),
  .reqOperand (reqOperand),
  .memRdEn    (memRdEn),
  .memRdAddr  (memRdAddr),
  .busy       (busy),
  .done       (done),
  .finalAddr  (finalAddr),
  .pageCrossed(pageCrossed)
);

// File: tb/operand_addr_unit_tb_top.sv
module operand_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = 2'b00;
  logic [15:0] reqOperand = '0;
  logic [7:0]  reqIndex = '0;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic        busy, done, pageCrossed;
  logic [15:0] finalAddr;

  int checks = 0;
  int failures = 0;
  logic [7:0] zpMem [256];

  always #5 clk = ~clk;

  operand_addr_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqOperand(reqOperand), .reqIndex(reqIndex), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .busy(busy), .done(done),
    .finalAddr(finalAddr), .pageCrossed(pageCrossed)
  );

  // page-zero memory model, one cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= zpMem[memRdAddr[7:0]];

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int expLatency(input logic [1:0] m, input logic carry);
    if (m == 2'b01) return 2 + int'(carry);
    if (m == 2'b10) return 4 + int'(carry);
    return 1;
  endfunction

  task automatic runReq(input logic [1:0] m, input logic [15:0] opnd,
                        input logic [7:0] idx, input bit spurious);
    logic [15:0] base, expAddr;
    logic [8:0]  lowSum;
    logic        carry;
    logic [7:0]  n;
    int          lat;
    string       tag;
    n = opnd[7:0];
    if (m == 2'b10) base = {zpMem[8'(n + 8'd1)], zpMem[n]};
    else            base = opnd;
    if (m == 2'b01 || m == 2'b10) begin
      lowSum  = {1'b0, base[7:0]} + {1'b0, idx};
      carry   = lowSum[8];
      expAddr = base + {8'h00, idx};
    end else begin
      carry   = 1'b0;
      expAddr = opnd;
    end
    lat = expLatency(m, carry);
    case (m)
      2'b00:   tag = "R2";
      2'b01:   tag = carry ? "R4" : "R3";
      2'b10:   tag = "R6";
      default: tag = "R9";
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqOperand = opnd; reqIndex = idx;
    @(negedge clk);
    reqValid = spurious;
    if (spurious) begin  // R8: unrelated request fields while busy
      reqMode = 2'($urandom_range(0, 3));
      reqOperand = ~opnd;
      reqIndex = ~idx;
    end
    for (int c = 1; c <= lat; c++) begin
      check("R7", "busy", busy, 1'b1);
      check(tag, "done timing", done, (c == lat));
      if (m == 2'b10) begin
        check("R5", "read strobe", memRdEn, (c == 1 || c == 2));
        if (c == 1) check("R5", "first read addr", memRdAddr, {8'h00, n});
        if (c == 2) check("R5", "second read addr", memRdAddr, {8'h00, 8'(n + 8'd1)});
      end else begin
        check("R5", "no read", memRdEn, 1'b0);
      end
      if (c == lat) begin
        check(tag, "final address", finalAddr, expAddr);
        check(tag, "page crossed", pageCrossed, carry);
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    reqValid = 1'b0;
    check("R7", "busy after done", busy, 1'b0);
    check("R7", "done pulse width", done, 1'b0);
    if (spurious) check("R8", "result under busy requests", finalAddr, expAddr);
    @(negedge clk);
    check("R10", "address held", finalAddr, expAddr);
    check("R10", "flag held", pageCrossed, carry);
  endtask

  initial begin
    #(10 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) zpMem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", busy, 1'b0);
    check("R1", "done after reset", done, 1'b0);
    check("R1", "read after reset", memRdEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy idle", busy, 1'b0);

    // directed corner cases
    runReq(2'b00, 16'hBEEF, 8'h44, 1'b0);   // R2 direct
    runReq(2'b11, 16'h1234, 8'hFF, 1'b0);   // R9 reserved as direct
    runReq(2'b01, 16'h1200, 8'h00, 1'b0);   // R3 zero index
    runReq(2'b01, 16'h12F0, 8'h0F, 1'b0);   // R3 exact 0xFF
    runReq(2'b01, 16'h12FF, 8'h01, 1'b0);   // R4 carry
    runReq(2'b01, 16'hFFFF, 8'hFF, 1'b1);   // R4 wrap to 0x00FE
    zpMem[8'hFF] = 8'hF0; zpMem[8'h00] = 8'h3A;
    runReq(2'b10, 16'h00FF, 8'h20, 1'b0);   // R6 wrap and carry
    runReq(2'b10, 16'h00FF, 8'h0F, 1'b1);   // R6 wrap, no carry
    zpMem[8'h40] = 8'h00; zpMem[8'h41] = 8'hFF;
    runReq(2'b10, 16'h7740, 8'hFF, 1'b0);   // R5 upper operand bits unused

    for (int k = 0; k < 400; k++) begin
      zpMem[8'($urandom)] = 8'($urandom);
      runReq(2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom),
             bit'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule